// File: doc/BRIEF.md
# Processor Address Decoder with Tightly Coupled Memory Windows

This block takes 32-bit access requests from one processor and decides which target each one belongs to. The targets are a small boot ROM near the top of the address space, an instruction tightly coupled memory (TCM) at address zero, a data TCM at a base that software can move, a mirrored 4 MiB main RAM, a shared RAM window and an I/O region. Each result carries a one-hot target select and a local offset that is already masked to the target's size, so a mirrored alias of any target lands on the same storage. An address that matches no target raises a miss flag. The memories and the I/O registers sit outside the block. The miss flag tells the fabric to return zero on a read and to drop a write.

The TCM windows depend on three configuration registers: the instruction TCM size, the data TCM base and the data TCM size. A single-cycle load strobe writes all three at once. Requests enter on a valid/ready channel and results leave on a second valid/ready channel, through one register stage. A request is taken on any cycle where the output stage is empty or is being emptied. A result stays unchanged until it is accepted. Results leave in the order their requests were accepted.

Top module: `adec_tcm_map`

## Requirements
- R1: A read whose address bits [31:12] equal 0xFFFF0 selects the boot ROM (select bit 0), with offset equal to address bits [11:0].
- R2: An address strictly below the instruction TCM size selects the instruction TCM (select bit 1), with offset equal to address bits [14:0].
- R3: An address with base <= address < base + size selects the data TCM (select bit 2), with offset equal to (address - base) bits [13:0].
- R4: When several rules match, the winner is chosen in this order: boot ROM (reads only), then instruction TCM, then data TCM, then the region decode on the top address byte.
- R5: If no earlier rule matches, top byte 0x02 selects main RAM (bit 3) with offset bits [21:0]. Top byte 0x03 selects shared RAM (bit 4) with offset bits [14:0]. Top byte 0x04 selects I/O (bit 5) with offset bits [23:0].
- R6: After reset the instruction TCM size is 0, the data TCM base is 0xFFFFFFFF and the data TCM size is 0, so neither TCM matches any address. The output channel is empty.
- R7: A write never selects the boot ROM. A write in the boot window falls through to the remaining rules.
- R8: An address that matches no rule produces miss = 1, an all-zero select and a zero offset. Otherwise exactly one select bit is set and miss = 0.
- R9: The data TCM end bound is computed with 33 bits, so a window near the top of the address space does not wrap around to low addresses.
- R10: req_ready = !rsp_valid || rsp_ready. While rsp_valid is high and rsp_ready is low, the result holds steady. Each accepted request gives exactly one result, in order.
- R11: A cycle with cfg_load high writes all three configuration registers. Requests accepted in later cycles use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load strobe for the configuration registers |
| cfg_itcm_size | input | 32 | New instruction TCM size |
| cfg_dtcm_base | input | 32 | New data TCM base |
| cfg_dtcm_size | input | 32 | New data TCM size |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_sel | output | 6 | One-hot target select: 0 boot, 1 ITCM, 2 DTCM, 3 main RAM, 4 shared RAM, 5 I/O |
| rsp_ofs | output | 24 | Masked local offset within the selected target |
| rsp_miss | output | 1 | No target matched |

## Verification
The hardest cases to reach are the ones where rules overlap. Examples are a data TCM placed over the boot window, where a read and a write to the same address must go to different targets, and a data TCM whose end passes 2^32. Neither case can happen from reset. The stimulus reaches them by loading the configuration registers first and then sending a read and a write to the same address. The back-pressure rules are exercised by a long stream of mixed addresses while the consumer's ready signal toggles at random.

// File: rtl/adec_pkg.sv
package adec_pkg;
  localparam int TGT_N = 6;

  typedef enum int unsigned {
    T_BOOT  = 0,
    T_ITCM  = 1,
    T_DTCM  = 2,
    T_MRAM  = 3,
    T_SHRAM = 4,
    T_IO    = 5
  } tgt_e;

  typedef struct packed {
    logic [31:0] itcm_size;
    logic [31:0] dtcm_base;
    logic [31:0] dtcm_size;
  } tcm_cfg_t;
endpackage

// File: rtl/adec_cfg_regs.sv
module adec_cfg_regs
  import adec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] itcm_size_in,
  input  logic [31:0] dtcm_base_in,
  input  logic [31:0] dtcm_size_in,
  output tcm_cfg_t    cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.itcm_size <= '0;
      cfg.dtcm_base <= '1;
      cfg.dtcm_size <= '0;
    end else if (load) begin
      cfg.itcm_size <= itcm_size_in;
      cfg.dtcm_base <= dtcm_base_in;
      cfg.dtcm_size <= dtcm_size_in;
    end
  end

  // R11: a load shows up in the registers on the next cycle
  AST_CFG_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cfg.dtcm_base == $past(dtcm_base_in) && cfg.itcm_size == $past(itcm_size_in)); // R11
endmodule

// File: rtl/adec_window.sv
module adec_window #(
  parameter int AW     = 32,
  parameter int MASK_W = 14
) (
  input  logic [AW-1:0]     addr,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     size,
  output logic              hit,
  output logic [MASK_W-1:0] ofs
);
  logic [AW:0]   a_ext;
  logic [AW:0]   lo_ext;
  logic [AW:0]   hi_ext;
  logic [AW-1:0] diff;

  always_comb begin
    a_ext  = {1'b0, addr};
    lo_ext = {1'b0, base};
    hi_ext = {1'b0, base} + {1'b0, size};
    hit    = (a_ext >= lo_ext) && (a_ext < hi_ext);
    diff   = addr - base;
    ofs    = diff[MASK_W-1:0];
  end
endmodule

// File: rtl/adec_region.sv
module adec_region #(
  parameter int         AW          = 32,
  parameter int         OFS_W       = 24,
  parameter int         BOOT_TAG_W  = 20,
  parameter logic [BOOT_TAG_W-1:0] BOOT_TAG = 20'hFFFF0,
  parameter logic [7:0] MRAM_CODE   = 8'h02,
  parameter logic [7:0] SHRAM_CODE  = 8'h03,
  parameter logic [7:0] IO_CODE     = 8'h04,
  parameter int         MRAM_MASK_W = 22,
  parameter int         SHRAM_MASK_W = 15,
  parameter int         IO_MASK_W   = 24
) (
  input  logic [AW-1:0]    addr,
  output logic             boot_hit,
  output logic [OFS_W-1:0] boot_ofs,
  output logic [2:0]       reg_sel,
  output logic [OFS_W-1:0] reg_ofs
);
  localparam int BOOT_OFS_W = AW - BOOT_TAG_W;

  logic [7:0] top;

  always_comb begin
    top      = addr[AW-1 -: 8];
    boot_hit = (addr[AW-1 -: BOOT_TAG_W] == BOOT_TAG);
    boot_ofs = OFS_W'(addr[BOOT_OFS_W-1:0]);
    reg_sel  = 3'b000;
    reg_ofs  = '0;
    unique case (top)
      MRAM_CODE: begin
        reg_sel = 3'b001;
        reg_ofs = OFS_W'(addr[MRAM_MASK_W-1:0]);
      end
      SHRAM_CODE: begin
        reg_sel = 3'b010;
        reg_ofs = OFS_W'(addr[SHRAM_MASK_W-1:0]);
      end
      IO_CODE: begin
        reg_sel = 3'b100;
        reg_ofs = OFS_W'(addr[IO_MASK_W-1:0]);
      end
      default: begin
        reg_sel = 3'b000;
        reg_ofs = '0;
      end
    endcase
  end
endmodule

// File: rtl/adec_tcm_map.sv
module adec_tcm_map
  import adec_pkg::*;
#(
  parameter int AW           = 32,
  parameter int ITCM_MASK_W  = 15,
  parameter int DTCM_MASK_W  = 14,
  parameter int MRAM_MASK_W  = 22,
  parameter int SHRAM_MASK_W = 15,
  parameter int IO_MASK_W    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [31:0]       cfg_itcm_size,
  input  logic [31:0]       cfg_dtcm_base,
  input  logic [31:0]       cfg_dtcm_size,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [5:0]        rsp_sel,
  output logic [23:0]       rsp_ofs,
  output logic              rsp_miss
);
  localparam int OFS_W  = 24;
  localparam int WIN_N  = 2;

  tcm_cfg_t cfg;

  adec_cfg_regs u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (cfg_load),
    .itcm_size_in (cfg_itcm_size),
    .dtcm_base_in (cfg_dtcm_base),
    .dtcm_size_in (cfg_dtcm_size),
    .cfg          (cfg)
  );

  logic [AW-1:0]    win_base [WIN_N];
  logic [AW-1:0]    win_size [WIN_N];
  logic [WIN_N-1:0] win_hit;
  logic [OFS_W-1:0] win_ofs  [WIN_N];

  assign win_base[0] = '0;
  assign win_size[0] = cfg.itcm_size;
  assign win_base[1] = cfg.dtcm_base;
  assign win_size[1] = cfg.dtcm_size;

  genvar g;
  generate
    for (g = 0; g < WIN_N; g++) begin : g_win
      localparam int MW = (g == 0) ? ITCM_MASK_W : DTCM_MASK_W;
      logic [MW-1:0] w_ofs;
      adec_window #(.AW(AW), .MASK_W(MW)) u_win (
        .addr (req_addr),
        .base (win_base[g]),
        .size (win_size[g]),
        .hit  (win_hit[g]),
        .ofs  (w_ofs)
      );
      assign win_ofs[g] = OFS_W'(w_ofs);
    end
  endgenerate

  logic             boot_hit;
  logic [OFS_W-1:0] boot_ofs;
  logic [2:0]       reg_sel;
  logic [OFS_W-1:0] reg_ofs;

  adec_region #(
    .AW(AW), .OFS_W(OFS_W),
    .MRAM_MASK_W(MRAM_MASK_W), .SHRAM_MASK_W(SHRAM_MASK_W), .IO_MASK_W(IO_MASK_W)
  ) u_region (
    .addr     (req_addr),
    .boot_hit (boot_hit),
    .boot_ofs (boot_ofs),
    .reg_sel  (reg_sel),
    .reg_ofs  (reg_ofs)
  );

  logic [TGT_N-1:0] dec_sel;
  logic [OFS_W-1:0] dec_ofs;
  logic             dec_miss;

  always_comb begin
    dec_sel  = '0;
    dec_ofs  = '0;
    dec_miss = 1'b0;
    if (boot_hit && !req_write) begin
      dec_sel[T_BOOT] = 1'b1;
      dec_ofs         = boot_ofs;
    end else if (win_hit[0]) begin
      dec_sel[T_ITCM] = 1'b1;
      dec_ofs         = win_ofs[0];
    end else if (win_hit[1]) begin
      dec_sel[T_DTCM] = 1'b1;
      dec_ofs         = win_ofs[1];
    end else if (reg_sel != 3'b000) begin
      dec_sel[T_IO:T_MRAM] = reg_sel;
      dec_ofs              = reg_ofs;
    end else begin
      dec_miss = 1'b1;
    end
  end

  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_sel   <= '0;
      rsp_ofs   <= '0;
      rsp_miss  <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_sel   <= dec_sel;
      rsp_ofs   <= dec_ofs;
      rsp_miss  <= dec_miss;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(rsp_sel) == (rsp_miss ? 0 : 1)); // R8
  AST_MISS_ZERO_OFS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> rsp_ofs == '0); // R8
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_sel) && $stable(rsp_ofs) && $stable(rsp_miss)); // R10
  AST_WRITE_NOT_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> !rsp_sel[T_BOOT]); // R7
  AST_BOOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && boot_hit) |=> rsp_sel[T_BOOT] && !rsp_miss); // R4
  AST_ITCM_OVER_DTCM: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && win_hit[0] && win_hit[1] && !boot_hit) |=> rsp_sel[T_ITCM]); // R4
endmodule

// File: tb/test_adec_tcm_map.sv
module test_adec_tcm_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_itcm_size = '0;
  logic [31:0] cfg_dtcm_base = '0;
  logic [31:0] cfg_dtcm_size = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [5:0]  rsp_sel;
  logic [23:0] rsp_ofs;
  logic        rsp_miss;

  adec_tcm_map i_adec_tcm_map (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_itcm_size(cfg_itcm_size), .cfg_dtcm_base(cfg_dtcm_base), .cfg_dtcm_size(cfg_dtcm_size),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_sel(rsp_sel), .rsp_ofs(rsp_ofs),
    .rsp_miss(rsp_miss)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [5:0]  sel;
    logic [23:0] ofs;
    logic        miss;
    logic [31:0] addr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   stall_mode = 0;
  bit   done = 0;

  logic [31:0] m_isz = 32'h0;
  logic [31:0] m_dbase = 32'hFFFF_FFFF;
  logic [31:0] m_dsz = 32'h0;

  function automatic exp_t model(input logic [31:0] a, input logic wr, input string tag);
    exp_t e;
    logic [32:0] hi;
    logic [31:0] d;
    e.sel = '0; e.ofs = '0; e.miss = 1'b0; e.addr = a; e.tag = tag;
    hi = {1'b0, m_dbase} + {1'b0, m_dsz};
    d = a - m_dbase;
    if (!wr && a[31:12] == 20'hFFFF0) begin e.sel = 6'b000001; e.ofs = {12'h0, a[11:0]}; end
    else if (a < m_isz) begin e.sel = 6'b000010; e.ofs = {9'h0, a[14:0]}; end
    else if (a >= m_dbase && {1'b0, a} < hi) begin e.sel = 6'b000100; e.ofs = {10'h0, d[13:0]}; end
    else if (a[31:24] == 8'h02) begin e.sel = 6'b001000; e.ofs = {2'h0, a[21:0]}; end
    else if (a[31:24] == 8'h03) begin e.sel = 6'b010000; e.ofs = {9'h0, a[14:0]}; end
    else if (a[31:24] == 8'h04) begin e.sel = 6'b100000; e.ofs = a[23:0]; end
    else e.miss = 1'b1;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic wr, input string tag);
    bit acc;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    do begin
      acc = req_ready;
      if (acc) q.push_back(model(a, wr, tag));
      @(negedge clk);
    end while (!acc);
    req_valid = 1'b0;
  endtask

  task automatic load_cfg(input logic [31:0] isz, input logic [31:0] db, input logic [31:0] dsz);
    @(negedge clk);
    cfg_load = 1'b1; cfg_itcm_size = isz; cfg_dtcm_base = db; cfg_dtcm_size = dsz;
    @(negedge clk);
    cfg_load = 1'b0;
    m_isz = isz; m_dbase = db; m_dsz = dsz;
  endtask

  // consumer ready
  initial begin
    forever begin
      @(posedge clk);
      #1 rsp_ready = stall_mode ? 1'($urandom_range(0, 1)) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit          prev_stall = 0;
    logic [5:0]  p_sel = '0;
    logic [23:0] p_ofs = '0;
    logic        p_miss = 1'b0;
    exp_t        e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall)
          check(rsp_valid && rsp_sel == p_sel && rsp_ofs == p_ofs && rsp_miss == p_miss, "R10",
                $sformatf("stalled result changed: sel %b ofs %h miss %b, expected sel %b ofs %h miss %b",
                          rsp_sel, rsp_ofs, rsp_miss, p_sel, p_ofs, p_miss));
        if (rsp_valid && rsp_ready) begin
          if (q.size() == 0) begin
            check(1'b0, "R10", $sformatf("result sel %b with nothing expected, expected none", rsp_sel));
          end else begin
            e = q.pop_front();
            check(rsp_sel == e.sel && rsp_ofs == e.ofs && rsp_miss == e.miss, e.tag,
                  $sformatf("addr %h: sel %b ofs %h miss %b, expected sel %b ofs %h miss %b",
                            e.addr, rsp_sel, rsp_ofs, rsp_miss, e.sel, e.ofs, e.miss));
          end
        end
        prev_stall = rsp_valid && !rsp_ready;
        p_sel = rsp_sel; p_ofs = rsp_ofs; p_miss = rsp_miss;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R6", $sformatf("rsp_valid %b during reset, expected 0", rsp_valid));
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R6",
          $sformatf("after reset valid %b ready %b, expected 0 1", rsp_valid, req_ready));

    // R6: both TCMs disabled out of reset
    send(32'h0000_0010, 1'b0, "R6");
    send(32'hFFFF_FFFF, 1'b0, "R6");
    // R1 boot reads, R7 write falls through
    send(32'hFFFF_0ABC, 1'b0, "R1");
    send(32'hFFFF_0FFF, 1'b0, "R1");
    send(32'hFFFF_0ABC, 1'b1, "R7");
    // R5 regions and mirrors
    send(32'h0234_5678, 1'b0, "R5");
    send(32'h02C1_2345, 1'b1, "R5");
    send(32'h03AB_CDEF, 1'b0, "R5");
    send(32'h0400_0247, 1'b1, "R5");
    // R8 unmapped
    send(32'h0500_0000, 1'b0, "R8");
    send(32'h0100_0000, 1'b1, "R8");

    // R11 / R2 / R3 / R4
    load_cfg(32'h0001_0000, 32'h027C_0000, 32'h0000_4000);
    send(32'h0000_C004, 1'b0, "R2");
    send(32'h0000_FFFF, 1'b1, "R2");
    send(32'h0001_0000, 1'b0, "R11");
    send(32'h027C_1234, 1'b0, "R3");
    send(32'h027C_4000, 1'b0, "R4");
    send(32'h027B_FFFF, 1'b1, "R4");

    load_cfg(32'h0000_0200, 32'h0000_0100, 32'h0000_0100);
    send(32'h0000_0150, 1'b0, "R4");
    send(32'h0000_0150, 1'b1, "R4");

    load_cfg(32'h0, 32'hFFFF_0000, 32'h0000_8000);
    send(32'hFFFF_0010, 1'b0, "R4");
    send(32'hFFFF_0010, 1'b1, "R7");
    send(32'hFFFF_7000, 1'b0, "R3");

    // R9 window near the top
    load_cfg(32'h0, 32'hFFFF_F000, 32'h0000_2000);
    send(32'hFFFF_F800, 1'b0, "R9");
    send(32'h0000_0400, 1'b0, "R9");
    send(32'h0200_0400, 1'b1, "R9");

    // R10 back-pressure with mixed traffic
    load_cfg(32'h0000_4000, 32'h0300_2000, 32'h0000_1000);
    stall_mode = 1;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      a = $urandom();
      case ($urandom_range(0, 6))
        0: a[31:12] = 20'hFFFF0;
        1: a = {18'h0, a[13:0]};
        2: a = {20'h03002, a[11:0]};
        3: a[31:24] = 8'h02;
        4: a[31:24] = 8'h03;
        5: a[31:24] = 8'h04;
        default: ;
      endcase
      send(a, 1'($urandom_range(0, 1)), "R10");
    end
    stall_mode = 0;

    repeat (20) @(negedge clk);
    check(q.size() == 0, "R10", $sformatf("%0d results missing, expected 0", q.size()));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule